// File: doc/BRIEF.md
# Byte-Command Controller for a Delay-Line Probe

This block turns single received bytes into operations on a 40-bit shift memory. Every byte that arrives from a serial receiver (8 data bits, one start bit, one stop bit, no parity, 9600 baud, least significant bit first, with framing done upstream) carries an operation code in its low nibble and an argument in its high nibble. The operations are: push a nibble into the memory; pop the top byte of the memory to a serial transmitter; overwrite the low 32 bits with one raw snapshot of a delay line; and collect a burst of eight 5-bit edge positions from a sampler, each pushed into the memory.

All data moves over valid/ready handshakes. The controller takes one byte at a time. It lowers `rx_ready` whenever an operation is still open, so a byte that arrives during that time waits at the receiver. A byte stays on `tx_data` until the transmitter accepts it. Requests to the sampler are levels. `snap_req` stays high until one `snap_valid` arrives. `scope_req` stays high until `scope_valid` has been seen eight times. A result strobe that arrives while its request is low is ignored. The bit-level serial logic and the delay line itself are outside this block.

Top module: `dly_cmd_ctrl`

## Requirements
- R1: After reset the memory holds all zeros, `rx_ready` is 1, and `tx_valid`, `snap_req` and `scope_req` are 0.
- R2: A byte accepted with code 0 in bits [3:0] shifts the memory left by 4 and places byte bits [7:4] into memory bits [3:0].
- R3: A byte accepted with code 1 raises `tx_valid` in the next cycle, with `tx_data` equal to memory bits [39:32]. The byte and `tx_valid` hold until `tx_ready` is seen. The memory then shifts left by 8 and fills with zeros. Bits [7:4] of the command byte are ignored.
- R4: A byte accepted with code 2 raises `snap_req` in the next cycle and holds it until `snap_valid`. At that point `snap_data` replaces memory bits [31:0], and bits [39:32] are left unchanged.
- R5: A byte accepted with code 3 raises `scope_req` in the next cycle and holds it for 8 `scope_valid` strobes. Each strobe shifts the memory left by 5 and places `scope_pos` into bits [4:0], so the first position ends up in bits [39:35].
- R6: Codes 4 to 15 leave the memory unchanged, produce no transmit byte and raise no request. `rx_ready` stays 1.
- R7: `rx_ready` is 0 while a transmit byte or a capture is pending, and at most one of `tx_valid`, `snap_req` and `scope_req` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Controller accepts a byte |
| rx_data | input | 8 | Received byte: code [3:0], argument [7:4] |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Byte to transmit |
| snap_req | output | 1 | Snapshot requested, held until answered |
| snap_valid | input | 1 | Snapshot result strobe |
| snap_data | input | 32 | Snapshot result |
| scope_req | output | 1 | Edge-position burst requested |
| scope_valid | input | 1 | One edge position available |
| scope_pos | input | 5 | Edge position value |

## Verification
The bench builds the block with its default parameters: a 40-bit memory, a 32-bit snapshot, 5-bit positions and a burst of 8. With these values the eight positions fill the memory exactly, so a burst can be read back whole as five bytes. With a snapshot narrower than the memory, the preserved top byte is visible at the port. Because nibble pushes and byte pops both fit exactly into 40 bits, the bench can load any pattern and read it back fully. This makes holds and zero fill observable through `tx_data` alone.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [2:0] {
    CMD_LOAD   = 3'd0,
    CMD_UNLOAD = 3'd1,
    CMD_SNAP   = 3'd2,
    CMD_SCOPE  = 3'd3,
    CMD_NOP    = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    MOP_HOLD = 3'd0,
    MOP_NIB  = 3'd1,
    MOP_BYTE = 3'd2,
    MOP_SNAP = 3'd3,
    MOP_POS  = 3'd4
  } mem_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_SNAP  = 2'd2,
    ST_SCOPE = 2'd3
  } state_e;
endpackage

// File: rtl/dlc_cmd_decode.sv
module dlc_cmd_decode
  import dlc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [BYTE_W-1:0]       byte_in,
  output cmd_e                    cmd,
  output logic [BYTE_W-NIB_W-1:0] arg
);
  logic [NIB_W-1:0] code;

  assign code = byte_in[NIB_W-1:0];
  assign arg  = byte_in[BYTE_W-1:NIB_W];

  always_comb begin
    case (code)
      NIB_W'(0): cmd = CMD_LOAD;
      NIB_W'(1): cmd = CMD_UNLOAD;
      NIB_W'(2): cmd = CMD_SNAP;
      NIB_W'(3): cmd = CMD_SCOPE;
      default:   cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/dlc_shift_mem.sv
module dlc_shift_mem
  import dlc_pkg::*;
#(
  parameter int MEM_W  = 40,
  parameter int NIB_W  = 4,
  parameter int BYTE_W = 8,
  parameter int SNAP_W = 32,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mem_op_e           op,
  input  logic [NIB_W-1:0]  nib,
  input  logic [SNAP_W-1:0] snap,
  input  logic [POS_W-1:0]  pos,
  output logic [BYTE_W-1:0] top_byte
);
  logic [MEM_W-1:0] mem_q;
  logic [MEM_W-1:0] mem_d;
  logic [MEM_W-1:0] snap_merge;

  generate
    if (SNAP_W < MEM_W) begin : g_partial
      assign snap_merge = {mem_q[MEM_W-1:SNAP_W], snap};
    end else begin : g_full
      assign snap_merge = snap[MEM_W-1:0];
    end
  endgenerate

  always_comb begin
    case (op)
      MOP_NIB:  mem_d = {mem_q[MEM_W-NIB_W-1:0], nib};
      MOP_BYTE: mem_d = {mem_q[MEM_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      MOP_SNAP: mem_d = snap_merge;
      MOP_POS:  mem_d = {mem_q[MEM_W-POS_W-1:0], pos};
      default:  mem_d = mem_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end

  assign top_byte = mem_q[MEM_W-1 -: BYTE_W];
endmodule

// File: rtl/dlc_ctrl_fsm.sv
module dlc_ctrl_fsm
  import dlc_pkg::*;
#(
  parameter int SCOPE_N = 8,
  localparam int CNT_W  = $clog2(SCOPE_N + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rx_valid,
  input  cmd_e    cmd,
  input  logic    tx_ready,
  input  logic    snap_valid,
  input  logic    scope_valid,
  output logic    rx_ready,
  output logic    tx_valid,
  output logic    snap_req,
  output logic    scope_req,
  output mem_op_e op
);
  state_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rx_fire;
  logic             last_pos;

  assign rx_ready  = (st_q == ST_IDLE);
  assign tx_valid  = (st_q == ST_SEND);
  assign snap_req  = (st_q == ST_SNAP);
  assign scope_req = (st_q == ST_SCOPE);
  assign rx_fire   = rx_valid && rx_ready;
  assign last_pos  = (cnt_q == CNT_W'(SCOPE_N - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    op    = MOP_HOLD;
    case (st_q)
      ST_IDLE: begin
        if (rx_fire) begin
          case (cmd)
            CMD_LOAD:   op = MOP_NIB;
            CMD_UNLOAD: st_d = ST_SEND;
            CMD_SNAP:   st_d = ST_SNAP;
            CMD_SCOPE: begin
              st_d  = ST_SCOPE;
              cnt_d = '0;
            end
            default: ;
          endcase
        end
      end
      ST_SEND: begin
        if (tx_ready) begin
          op   = MOP_BYTE;
          st_d = ST_IDLE;
        end
      end
      ST_SNAP: begin
        if (snap_valid) begin
          op   = MOP_SNAP;
          st_d = ST_IDLE;
        end
      end
      ST_SCOPE: begin
        if (scope_valid) begin
          op    = MOP_POS;
          cnt_d = cnt_q + 1'b1;
          if (last_pos) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dly_cmd_ctrl.sv
module dly_cmd_ctrl
  import dlc_pkg::*;
#(
  parameter int MEM_W   = 40,
  parameter int BYTE_W  = 8,
  parameter int NIB_W   = 4,
  parameter int SNAP_W  = 32,
  parameter int POS_W   = 5,
  parameter int SCOPE_N = 8,
  localparam int ARG_W  = BYTE_W - NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              snap_req,
  input  logic              snap_valid,
  input  logic [SNAP_W-1:0] snap_data,
  output logic              scope_req,
  input  logic              scope_valid,
  input  logic [POS_W-1:0]  scope_pos
);
  cmd_e             cmd;
  logic [ARG_W-1:0] arg;
  mem_op_e          op;

  dlc_cmd_decode #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) dec_i (
    .byte_in (rx_data),
    .cmd     (cmd),
    .arg     (arg)
  );

  dlc_ctrl_fsm #(.SCOPE_N(SCOPE_N)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .cmd         (cmd),
    .tx_ready    (tx_ready),
    .snap_valid  (snap_valid),
    .scope_valid (scope_valid),
    .rx_ready    (rx_ready),
    .tx_valid    (tx_valid),
    .snap_req    (snap_req),
    .scope_req   (scope_req),
    .op          (op)
  );

  dlc_shift_mem #(
    .MEM_W(MEM_W), .NIB_W(ARG_W), .BYTE_W(BYTE_W),
    .SNAP_W(SNAP_W), .POS_W(POS_W)
  ) mem_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .nib      (arg),
    .snap     (snap_data),
    .pos      (scope_pos),
    .top_byte (tx_data)
  );
endmodule

// File: rtl/dly_cmd_ctrl_chk.sv
module dly_cmd_ctrl_chk #(
  parameter int BYTE_W = 8,
  parameter int SNAP_W = 32,
  parameter int POS_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [BYTE_W-1:0] rx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              snap_req,
  input logic              snap_valid,
  input logic [SNAP_W-1:0] snap_data,
  input logic              scope_req,
  input logic              scope_valid,
  input logic [POS_W-1:0]  scope_pos
);
  logic       acc;
  logic [3:0] code;
  assign acc  = rx_valid && rx_ready;
  assign code = rx_data[3:0];

  p_busy_blocks_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !(tx_valid || snap_req || scope_req));
  p_one_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, snap_req, scope_req}));
  p_load_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && code == 4'd0) |=> rx_ready);
  p_unload_offers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && code == 4'd1) |=> tx_valid);
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_snap_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && code == 4'd2) |=> snap_req);
  p_snap_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_req && snap_valid) |=> rx_ready);
  p_scope_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && code == 4'd3) |=> scope_req);
  p_nop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && code >= 4'd4) |=> (rx_ready && !tx_valid));
endmodule

bind dly_cmd_ctrl dly_cmd_ctrl_chk #(.BYTE_W(BYTE_W), .SNAP_W(SNAP_W), .POS_W(POS_W)) chk_i (.*);

// File: tb/dly_cmd_ctrl_tb_top.sv
module dly_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  // each entry: {received byte, expected transmit byte when code is 1}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h5700,
    16'h5000, 16'h6000, 16'h7000, 16'h8000, 16'h9000, 16'hA000,
    16'h0112, 16'hF134, 16'h0156, 16'h0178, 16'h019A, 16'h0100
  };

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic snap_req, snap_valid = 0;
  logic [31:0] snap_data = 0;
  logic scope_req, scope_valid = 0;
  logic [4:0] scope_pos = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_cmd_ctrl dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic read_byte(input int stall, output logic [7:0] b);
    send_byte(8'h01);
    for (int i = 0; i < stall; i++) begin
      chk("R3 hold valid", tx_valid, 1);
      chk("R7 rx blocked", rx_ready, 0);
      @(negedge clk);
    end
    while (!tx_valid) @(negedge clk);
    b = tx_data;
    tx_ready = 1;
    @(posedge clk);
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic load40(input logic [39:0] v);
    for (int i = 9; i >= 0; i--) send_byte({v[i*4 +: 4], 4'h0});
  endtask

  task automatic read40(input string req, input logic [39:0] exp);
    logic [7:0] b;
    for (int i = 4; i >= 0; i--) begin
      read_byte(0, b);
      chk(req, b, exp[i*8 +: 8]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [4:0] p [8];
    logic [39:0] sc;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_ready", rx_ready, 1);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 snap_req", snap_req, 0);
    chk("R1 scope_req", scope_req, 0);
    read_byte(0, b);
    chk("R1 memory zero", b, 8'h00);

    // table: R2 nibble loads, R6 no-op mid-stream, R3 byte pops
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][11:8] == 4'h1) begin
        read_byte(0, b);
        chk("R3 table pop", b, VEC[k][7:0]);
      end else begin
        send_byte(VEC[k][15:8]);
        chk("R2 R6 stays ready", rx_ready, 1);
      end
    end

    // R3 back-pressure on the transmitter
    load40(40'hA5_00_00_00_00);
    read_byte(4, b);
    chk("R3 stalled byte", b, 8'hA5);

    // R4 snapshot keeps top byte
    load40(40'hFE_DCBA_9876);
    fork
      send_byte(8'h02);
      begin
        @(negedge clk); while (!snap_req) @(negedge clk);
        repeat (3) begin chk("R7 rx blocked in snap", rx_ready, 0); @(negedge clk); end
        snap_valid = 1; snap_data = 32'h1122_3344;
        @(posedge clk); @(negedge clk);
        snap_valid = 0;
      end
    join
    chk("R4 request dropped", snap_req, 0);
    read40("R4 snapshot merge", 40'hFE_1122_3344);

    // R5 scope burst
    p = '{5'h1F, 5'h00, 5'h15, 5'h03, 5'h07, 5'h10, 5'h0A, 5'h11};
    sc = {p[0], p[1], p[2], p[3], p[4], p[5], p[6], p[7]};
    fork
      send_byte(8'hE3);
      begin
        @(negedge clk); while (!scope_req) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          chk("R5 request held", scope_req, 1);
          chk("R7 rx blocked in scope", rx_ready, 0);
          scope_valid = 1; scope_pos = p[i];
          @(posedge clk); @(negedge clk);
          scope_valid = 0;
          @(negedge clk);
        end
      end
    join
    chk("R5 request dropped", scope_req, 0);
    chk("R5 ready after burst", rx_ready, 1);
    read40("R5 scope contents", sc);

    // R6 every undefined code
    load40(40'hC3_C3C3_C3C3);
    for (int c = 4; c < 16; c++) begin
      send_byte({4'hF, 4'(c)});
      chk("R6 no tx", tx_valid, 0);
      chk("R6 no request", snap_req | scope_req, 0);
    end
    read40("R6 memory unchanged", 40'hC3_C3C3_C3C3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule